// File: doc/BRIEF.md
# High-Speed Clock Pin Mode Register

This block is the byte-wide control register that sets how the two high-speed system clock pins of a microcontroller are used. The pins can act as plain I/O, drive a crystal or ceramic resonator, or accept an external clock on the second pin while the first pin stays I/O. The register also holds a gain select bit for the oscillator amplifier. Two read-only bits report the mode of the subsystem clock pins.

The gain select bit takes one write per reset. When that bit goes from 0 to 1, the block gates the CPU clock enable low for a fixed stall. The same stall follows a release from STOP mode when the gain bit is 1 and the CPU is not running from the crystal oscillator. The two pin-mode bits change only while the main oscillator is reported stopped. The stall length is derived from parameters that give the reference clock frequency and the minimum stall time.

Top module: `hsclk_mode_reg`

## Requirements
- R1: After a synchronous reset, `cpu_clk_en` is 1, `hs_pin_mode` is 0 and `gain_high` is 0. A read of the register address returns 0 in bits 7, 6 and 3..0, and `sub_pin_mode` in bits 5..4.
- R2: The register answers only at address `REG_ADDR` (default 16'hFF9F). Reads of any other address return 00h. Writes to any other address change nothing.
- R3: `hs_pin_mode` is decoded from bit 7 (external-clock select) and bit 6 (oscillator select). Bit 6 = 0 gives 0 (I/O port) whatever bit 7 holds. Bit 7 = 0 with bit 6 = 1 gives 1 (resonator). Bit 7 = 1 with bit 6 = 1 gives 2 (external clock). The value 3 never appears.
- R4: Bits 7 and 6 take write data only when `main_osc_off` is 1 at the write edge. Otherwise they keep their values.
- R5: Bit 0 (gain select, mirrored on `gain_high`) is written by the first write to the register after reset, whatever value that write carries. Every later write leaves it unchanged until the next reset.
- R6: When a write raises the gain bit from 0 to 1, `cpu_clk_en` is 0 for exactly STALL_CYCLES clock cycles, beginning with the cycle after the write edge. STALL_CYCLES is 250 with the default parameters (5 us at 50 MHz).
- R7: A `stop_exit` pulse while the gain bit is 1 and `cpu_on_xtal` is 0 holds `cpu_clk_en` at 0 for STALL_CYCLES cycles, beginning with the next cycle. A pulse with the gain bit at 0, or with `cpu_on_xtal` at 1, starts no stall.
- R8: Bits 5..4 read the live value of `sub_pin_mode`, and bits 3..1 read 0. Writes to bits 5..1 are ignored.
- R9: A single write that sets the gain bit and tries a mode change while `main_osc_off` is 0 still sets the gain bit and starts the stall. The mode bits stay as they were.
- R10: A stall trigger that arrives while a stall is running reloads the full STALL_CYCLES count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| main_osc_off | input | 1 | 1 while the main oscillator is stopped |
| stop_exit | input | 1 | One-cycle pulse on release from STOP mode |
| cpu_on_xtal | input | 1 | 1 while the CPU is clocked from the crystal oscillator |
| sub_pin_mode | input | 2 | Subsystem clock pin mode, reported in bits 5..4 |
| hs_pin_mode | output | 2 | Decoded pin mode: 0 I/O port, 1 resonator, 2 external clock |
| gain_high | output | 1 | Current gain select bit |
| cpu_clk_en | output | 1 | CPU clock enable, 0 during a stall |

## Verification
Two functions can act on the same edge. One write can raise the gain bit and also try a mode change that the stopped-oscillator gate refuses. A `stop_exit` pulse can also arrive during a stall or on the edge of a gain write. Directed sequences force both collisions on purpose. Random traffic then mixes writes, gate states and STOP releases across resets. In every cycle a bench reference model predicts the register contents, the pin mode and the stall count. Each case is judged by whether the gain bit landed, the mode bits held, and the clock enable stayed low for the exact reloaded count.

// File: rtl/hsclk_pkg.sv
package hsclk_pkg;

    typedef enum logic [1:0] {
        PIN_PORT      = 2'd0,
        PIN_RESONATOR = 2'd1,
        PIN_EXTCLK    = 2'd2
    } hs_pin_mode_e;

    // Register image; bit positions are fixed by software decoding.
    typedef struct packed {
        logic       ext_sel;   // bit 7
        logic       osc_sel;   // bit 6
        logic [1:0] sub_stat;  // bits 5..4
        logic [2:0] rsvd;      // bits 3..1
        logic       gain;      // bit 0
    } mode_reg_t;

    function automatic hs_pin_mode_e decode_pins(input logic ext_sel, input logic osc_sel);
        if (!osc_sel)
            return PIN_PORT;
        else if (ext_sel)
            return PIN_EXTCLK;
        else
            return PIN_RESONATOR;
    endfunction

    // Ceiling of clock cycles needed to cover a time in nanoseconds.
    function automatic int stall_cycles(input longint ref_hz, input longint stall_ns);
        longint prod;
        prod = ref_hz * stall_ns;
        return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

endpackage

// File: rtl/hsclk_field_ctl.sv
module hsclk_field_ctl (
    input  logic clk,
    input  logic rst,
    input  logic wr_hit,
    input  logic w_ext,
    input  logic w_osc,
    input  logic w_gain,
    input  logic main_osc_off,
    output logic ext_q,
    output logic osc_q,
    output logic gain_q,
    output logic gain_set
);

    logic gain_lock;

    // Gain field is open only for the first register write after reset.
    assign gain_set = wr_hit & ~gain_lock & w_gain & ~gain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q     <= 1'b0;
            osc_q     <= 1'b0;
            gain_q    <= 1'b0;
            gain_lock <= 1'b0;
        end else if (wr_hit) begin
            if (main_osc_off) begin
                ext_q <= w_ext;
                osc_q <= w_osc;
            end
            if (!gain_lock) begin
                gain_q    <= w_gain;
                gain_lock <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hsclk_stall_timer.sv
module hsclk_stall_timer #(
    parameter int LEN = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic run_en
);

    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= CW'(LEN);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign run_en = (cnt == '0);

endmodule

// File: rtl/hsclk_mode_reg.sv
module hsclk_mode_reg
    import hsclk_pkg::*;
#(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFF9F,
    parameter longint          REF_CLK_HZ = 50_000_000,
    parameter longint          STALL_NS   = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              main_osc_off,
    input  logic              stop_exit,
    input  logic              cpu_on_xtal,
    input  logic [1:0]        sub_pin_mode,
    output logic [1:0]        hs_pin_mode,
    output logic              gain_high,
    output logic              cpu_clk_en
);

    localparam int STALL_CYCLES = stall_cycles(REF_CLK_HZ, STALL_NS);

    mode_reg_t wr_img;
    mode_reg_t rd_img;
    logic      addr_hit;
    logic      wr_hit;
    logic      ext_q, osc_q, gain_q;
    logic      gain_set;
    logic      stop_stall;
    logic      stall_load;

    assign wr_img   = mode_reg_t'(bus_wdata);
    assign addr_hit = (bus_addr == REG_ADDR);
    assign wr_hit   = bus_we & addr_hit;

    hsclk_field_ctl u_fields (
        .clk          (clk),
        .rst          (rst),
        .wr_hit       (wr_hit),
        .w_ext        (wr_img.ext_sel),
        .w_osc        (wr_img.osc_sel),
        .w_gain       (wr_img.gain),
        .main_osc_off (main_osc_off),
        .ext_q        (ext_q),
        .osc_q        (osc_q),
        .gain_q       (gain_q),
        .gain_set     (gain_set)
    );

    assign stop_stall = stop_exit & gain_q & ~cpu_on_xtal;
    assign stall_load = gain_set | stop_stall;

    hsclk_stall_timer #(.LEN(STALL_CYCLES)) u_stall (
        .clk    (clk),
        .rst    (rst),
        .load   (stall_load),
        .run_en (cpu_clk_en)
    );

    always_comb begin
        rd_img.ext_sel  = ext_q;
        rd_img.osc_sel  = osc_q;
        rd_img.sub_stat = sub_pin_mode;
        rd_img.rsvd     = '0;
        rd_img.gain     = gain_q;
    end

    assign bus_rdata   = addr_hit ? 8'(rd_img) : 8'h00;
    assign hs_pin_mode = 2'(decode_pins(ext_q, osc_q));
    assign gain_high   = gain_q;

endmodule

// File: rtl/hsclk_mode_reg_chk.sv
module hsclk_mode_reg_chk #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFF9F
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [7:0]        bus_rdata,
    input logic              main_osc_off,
    input logic              stop_exit,
    input logic              cpu_on_xtal,
    input logic [1:0]        sub_pin_mode,
    input logic [1:0]        hs_pin_mode,
    input logic              gain_high,
    input logic              cpu_clk_en
);

    // R2
    foreign_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != REG_ADDR) |-> (bus_rdata == 8'h00));

    // R3
    pin_mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        hs_pin_mode != 2'd3);

    // R4
    mode_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_pin_mode != $past(hs_pin_mode)) |-> $past(bus_we && (bus_addr == REG_ADDR) && main_osc_off));

    // R5
    gain_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !$fell(gain_high));

    // R6
    gain_rise_stall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gain_high) |-> !cpu_clk_en);

    // R7
    stop_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_exit && gain_high && !cpu_on_xtal) |=> !cpu_clk_en);

    // R8
    status_field_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_ADDR) |-> (bus_rdata[5:4] == sub_pin_mode && bus_rdata[3:1] == 3'b000));

endmodule

bind hsclk_mode_reg hsclk_mode_reg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_rdata    (bus_rdata),
    .main_osc_off (main_osc_off),
    .stop_exit    (stop_exit),
    .cpu_on_xtal  (cpu_on_xtal),
    .sub_pin_mode (sub_pin_mode),
    .hs_pin_mode  (hs_pin_mode),
    .gain_high    (gain_high),
    .cpu_clk_en   (cpu_clk_en)
);

// File: tb/hsclk_mode_reg_test.sv
`timescale 1ns/1ps
module hsclk_mode_reg_test;

    localparam logic [15:0] ADDR  = 16'hFF9F;
    localparam int          STALL = 250;   // 5 us at 50 MHz

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        main_osc_off = 1'b0;
    logic        stop_exit = 1'b0;
    logic        cpu_on_xtal = 1'b0;
    logic [1:0]  sub_pin_mode = '0;
    logic [1:0]  hs_pin_mode;
    logic        gain_high;
    logic        cpu_clk_en;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    bit m_ext, m_osc, m_gain, m_lock;
    int m_cnt;

    always #10 clk = ~clk;

    hsclk_mode_reg uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .main_osc_off(main_osc_off),
        .stop_exit(stop_exit), .cpu_on_xtal(cpu_on_xtal), .sub_pin_mode(sub_pin_mode),
        .hs_pin_mode(hs_pin_mode), .gain_high(gain_high), .cpu_clk_en(cpu_clk_en)
    );

    function automatic int exp_mode(bit e, bit o);
        if (!o) return 0;
        return e ? 2 : 1;
    endfunction

    function automatic int exp_read(logic [15:0] a, logic [1:0] s);
        if (a != ADDR) return 0;
        return {m_ext, m_osc, s, 3'b000, m_gain};
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_we = 1'b0; stop_exit = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_ext = 0; m_osc = 0; m_gain = 0; m_lock = 0; m_cnt = 0;
    endtask

    // One bus cycle: drive at negedge, check read, step model, check state.
    task automatic cycle(logic [15:0] a, bit we, logic [7:0] wd, bit off,
                         bit stp, bit xt, logic [1:0] sub);
        bit reload;
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = wd; main_osc_off = off;
        stop_exit = stp; cpu_on_xtal = xt; sub_pin_mode = sub;
        #1;
        chk(int'(bus_rdata) == exp_read(a, sub), "R2/R8", "read data",
            int'(bus_rdata), exp_read(a, sub));
        reload = 0;
        if (stp && m_gain && !xt) reload = 1;
        if (we && a == ADDR) begin
            if (off) begin m_ext = wd[7]; m_osc = wd[6]; end
            if (!m_lock) begin
                if (wd[0] && !m_gain) reload = 1;
                m_gain = wd[0];
                m_lock = 1;
            end
        end
        m_cnt = reload ? STALL : (m_cnt > 0 ? m_cnt - 1 : 0);
        @(posedge clk);
        #1;
        chk(int'(hs_pin_mode) == exp_mode(m_ext, m_osc), "R3/R4", "pin mode",
            int'(hs_pin_mode), exp_mode(m_ext, m_osc));
        chk(gain_high == m_gain, "R5", "gain bit", int'(gain_high), int'(m_gain));
        chk(cpu_clk_en == (m_cnt == 0), "R6/R7", "clock enable",
            int'(cpu_clk_en), int'(m_cnt == 0));
    endtask

    task automatic idle(int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            cycle(16'h0000, 0, 8'h00, 0, 0, 0, 2'b01);
            if (!cpu_clk_en) lows++;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int lows;
        void'($urandom(32'h0000_51A7));
        sub_pin_mode = 2'b10;
        do_reset();
        bus_addr = ADDR;
        #1;
        // R1 reset state
        chk(cpu_clk_en == 1'b1, "R1", "enable after reset", int'(cpu_clk_en), 1);
        chk(hs_pin_mode == 2'd0, "R1", "pin mode after reset", int'(hs_pin_mode), 0);
        chk(gain_high == 1'b0, "R1", "gain after reset", int'(gain_high), 0);
        chk(bus_rdata == 8'h20, "R1", "read after reset", int'(bus_rdata), 32);

        // R2 write elsewhere carries gain and mode: nothing changes
        cycle(16'hFF9E, 1, 8'hC1, 1, 0, 0, 2'b00);
        chk(gain_high == 0 && hs_pin_mode == 0, "R2", "foreign write ignored",
            int'({gain_high, hs_pin_mode}), 0);

        // R9 gain set with refused mode change
        cycle(ADDR, 1, 8'hFF, 0, 0, 0, 2'b11);
        chk(gain_high == 1, "R9", "gain applied", int'(gain_high), 1);
        chk(hs_pin_mode == 0, "R9", "mode held", int'(hs_pin_mode), 0);
        chk(cpu_clk_en == 0, "R9", "stall started", int'(cpu_clk_en), 0);
        idle(STALL + 5, lows);
        // R6 the write cycle was the first low cycle
        chk(lows + 1 == STALL, "R6", "stall length", lows + 1, STALL);

        // R5 later write of 0 ignored
        cycle(ADDR, 1, 8'h00, 1, 0, 0, 2'b00);
        chk(gain_high == 1, "R5", "gain locked", int'(gain_high), 1);

        // R3 encodings, R4 gate
        cycle(ADDR, 1, 8'h40, 1, 0, 0, 2'b00);
        chk(hs_pin_mode == 1, "R3", "resonator", int'(hs_pin_mode), 1);
        cycle(ADDR, 1, 8'hC0, 0, 0, 0, 2'b00);
        chk(hs_pin_mode == 1, "R4", "refused change", int'(hs_pin_mode), 1);
        cycle(ADDR, 1, 8'hC0, 1, 0, 0, 2'b00);
        chk(hs_pin_mode == 2, "R3", "external clock", int'(hs_pin_mode), 2);
        cycle(ADDR, 1, 8'h80, 1, 0, 0, 2'b00);
        chk(hs_pin_mode == 0, "R3", "port with ext bit", int'(hs_pin_mode), 0);
        // R8 write to status and reserved bits ignored
        cycle(ADDR, 1, 8'h3E, 1, 0, 0, 2'b01);
        #1 chk(bus_rdata == 8'h11, "R8", "status bits", int'(bus_rdata), 17);

        // R7 STOP release stall, and R10 reload
        cycle(ADDR, 0, 8'h00, 0, 1, 0, 2'b00);
        chk(cpu_clk_en == 0, "R7", "stop stall", int'(cpu_clk_en), 0);
        idle(99, lows);
        cycle(ADDR, 0, 8'h00, 0, 1, 0, 2'b00);
        idle(STALL + 5, lows);
        chk(lows + 1 == STALL, "R10", "reloaded length", lows + 1, STALL);
        cycle(ADDR, 0, 8'h00, 0, 1, 1, 2'b00);
        chk(cpu_clk_en == 1, "R7", "xtal source no stall", int'(cpu_clk_en), 1);

        // R5 lock per reset: first write 0, then 1 ignored
        do_reset();
        cycle(ADDR, 0, 8'h00, 0, 1, 0, 2'b00);
        chk(cpu_clk_en == 1, "R7", "gain 0 no stall", int'(cpu_clk_en), 1);
        cycle(ADDR, 1, 8'h00, 0, 0, 0, 2'b00);
        cycle(ADDR, 1, 8'h01, 0, 0, 0, 2'b00);
        chk(gain_high == 0 && cpu_clk_en == 1, "R5", "second write ignored",
            int'({gain_high, cpu_clk_en}), 1);

        // Random traffic with periodic resets
        for (int blk = 0; blk < 4; blk++) begin
            do_reset();
            for (int i = 0; i < 900; i++) begin
                logic [15:0] a;
                a = ($urandom % 4 != 0) ? ADDR : 16'($urandom);
                cycle(a, ($urandom % 3) == 0, 8'($urandom), 1'($urandom),
                      ($urandom % 40) == 0, 1'($urandom), 2'($urandom));
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule